// File: doc/BRIEF.md
# Audio Sample FIFO Controller

This block sits between a register-mapped host bus and a serial audio codec. It holds one FIFO of outgoing (replay) samples and one FIFO of incoming (record) samples. Each FIFO word is a 32-bit stereo sample made of two 16-bit channels. Every sample period the block shifts one word out to the codec and one word in from it. The host, or a DMA engine driven by the two request lines, keeps the replay FIFO topped up and the record FIFO drained.

The codec master clock is derived from the block clock, nominally 49.152 MHz. A programmable divide-by-(DIV+2) stage produces it. One audio frame lasts 256 master clocks, so the sample rate is the master clock divided by 256. A frame carries 32 bit slots of 8 master clocks each, sent most significant bit first. The left channel occupies the upper 16 bits and is sent while the word-select line is high. Faults are latched into sticky flags that software clears by writing ones. A replay FIFO that runs dry plays a zero sample. A replay write to a full FIFO is discarded. A frame captured into a full record FIFO is lost. A record read from an empty FIFO returns zero.

Register word addresses on `bus_addr`:
- 0 control: bit 0 is replay enable, bit 1 is record enable, bits 7:4 are write-one-to-clear for the flags.
- 1 status: read-only.
- 2 divider: DIV in bits 4:0.
- 3 replay data: write only.
- 4 record data: read only.

Top module: `audio_fifo_ctrl`

## Requirements
- R1: The master clock period is DIV+2 block clocks, where DIV is bits 4:0 of the divider register at address 2. DIV reads back unchanged and is 0 after reset.
- R2: For a divisor N, `mclk_o` is high for ceil(N/2) block clocks and low for floor(N/2) block clocks.
- R3: A frame is 256 master clocks long. `lrck_o` is high for the first 128 and low for the last 128. The word is shifted out on `sdo_o` most significant bit first, one bit per 8 master clocks, starting at the rising edge of `lrck_o`.
- R4: `sdi_i` is sampled once per bit slot and the 32 bits are assembled most significant bit first. With `sdo_o` looped back to `sdi_i`, replay words come back from the record data register unchanged and in write order.
- R5: When replay is enabled and the replay FIFO is empty at the fetch for a new frame, that frame carries an all-zero word and status bit 5 (replay underflow) is set.
- R6: A write to the replay data register while the replay FIFO holds DEPTH words is dropped: the level stays at DEPTH and status bit 4 (replay overflow) is set.
- R7: A record word captured while the record FIFO is full is dropped and sets status bit 6. A read of an empty record FIFO returns 0 and sets status bit 7.
- R8: The status flags in bits 7:4 stay set until a control write with a 1 in the same bit position. Writing 0 there leaves them unchanged.
- R9: Control bit 0 enables replay and bit 1 enables recording. A control write that changes an enable from 1 to 0 empties the matching FIFO.
- R10: `play_dreq` is high one cycle after replay is enabled with the replay level at most DEPTH/2. `rec_dreq` is high one cycle after recording is enabled with the record level at least DEPTH/2. Otherwise each is low.
- R11: Status holds replay enable in bit 0, record enable in bit 1, the replay level in bits 12:8 and the record level in bits 20:16. It reads 0 after reset.
- R12: Read data is presented on `bus_rdata` in the cycle after `bus_rd` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the master-clock source |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after the read strobe |
| play_dreq | output | 1 | Replay DMA request |
| rec_dreq | output | 1 | Record DMA request |
| mclk_o | output | 1 | Codec master clock |
| lrck_o | output | 1 | Frame word select, high for the left channel |
| bclk_o | output | 1 | Bit clock, one period per bit slot |
| sdo_o | output | 1 | Serial replay data to the codec |
| sdi_i | input | 1 | Serial record data from the codec |

## Verification
The assertions check several properties on every cycle:
- The FIFO level never exceeds its depth.
- A write into a full FIFO never changes the level.
- Each master-clock tick lines up with a rising edge of `mclk_o`.
- The frame-select line moves only on ticks.
- Sticky flags never drop without a clearing write.
- The replay request stays low while replay is off.

Only the bench scenarios can show the end-to-end behaviour: word ordering through the serial loopback, zero insertion after the replay FIFO runs dry, the exact high and low lengths of the divided clock, and record overflow after a long unattended capture.

// File: rtl/audio_fifo_pkg.sv
package audio_fifo_pkg;

  localparam int SAMPLE_W = 32;
  localparam int ADDR_W   = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL    = 3'd0,
    REG_STATUS  = 3'd1,
    REG_MCLKDIV = 3'd2,
    REG_PLAY    = 3'd3,
    REG_REC     = 3'd4
  } reg_addr_e;

  // flag vector index; status / clear bit is FLAG_BASE + index
  localparam int FLAG_PLAY_OVF = 0;
  localparam int FLAG_PLAY_UNF = 1;
  localparam int FLAG_REC_OVF  = 2;
  localparam int FLAG_REC_UNF  = 3;
  localparam int FLAG_BASE     = 4;
  localparam int NUM_FLAGS     = 4;

  localparam int PLAY_LVL_LSB = 8;
  localparam int REC_LVL_LSB  = 16;

endpackage

// File: rtl/audio_sync_fifo.sv
module audio_sync_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [AW:0]   level,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          push_ok, pop_ok;

  assign full    = (cnt == (AW+1)'(DEPTH));
  assign empty   = (cnt == '0);
  assign level   = cnt;
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;

  // storage without reset so a block RAM can be inferred
  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (pop_ok) dout <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= wp + 1'b1;
      if (pop_ok)  rp <= rp + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    level <= (AW+1)'(DEPTH)); // R6

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    push && full && !pop && !flush |=> level == $past(level)); // R6

endmodule

// File: rtl/audio_mclk_div.sv
module audio_mclk_div #(
  parameter int DIV_W = 5,
  localparam int CW   = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             mclk_o,
  output logic             tick_o
);

  logic [CW-1:0] cnt, n_lat;
  logic [CW-1:0] cnt_nx, n_nx, hi_nx;
  logic          wrap;

  always_comb begin
    wrap   = (cnt == n_lat - 1'b1);
    cnt_nx = wrap ? '0 : cnt + 1'b1;
    // divisor is latched only at a period boundary
    n_nx   = wrap ? ({1'b0, div} + CW'(2)) : n_lat;
    hi_nx  = CW'((n_nx + 1'b1) >> 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      n_lat  <= CW'(2);
      mclk_o <= 1'b0;
      tick_o <= 1'b0;
    end else begin
      cnt    <= cnt_nx;
      n_lat  <= n_nx;
      mclk_o <= (cnt_nx < hi_nx);
      tick_o <= (cnt_nx == '0);
    end
  end

  AST_TICK_RISE: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> $rose(mclk_o)); // R2

endmodule

// File: rtl/audio_codec_serdes.sv
module audio_codec_serdes #(
  parameter int W         = 32,
  parameter int FRAME_LEN = 256,
  localparam int FCW      = $clog2(FRAME_LEN),
  localparam int SLOT     = FRAME_LEN / W,
  localparam int SB       = $clog2(SLOT)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         play_en,
  input  logic         rec_en,
  input  logic         play_empty,
  input  logic [W-1:0] play_word,
  output logic         play_pop,
  output logic         underrun_o,
  output logic         rec_push_o,
  output logic [W-1:0] rec_word_o,
  output logic         lrck_o,
  output logic         bclk_o,
  output logic         sdo_o,
  input  logic         sdi_i
);

  logic [FCW-1:0] fcnt;
  logic [W-1:0]   hold, tx_sr, rx_sr;
  logic           pop_q, rec_pend, rec_armed;
  logic           fetch, frame_end, shift_ev, samp_ev;

  always_comb begin
    fetch     = tick && (fcnt == FCW'(FRAME_LEN - 2));
    frame_end = tick && (fcnt == FCW'(FRAME_LEN - 1));
    shift_ev  = tick && (fcnt[SB-1:0] == SB'(SLOT - 1)) && !frame_end;
    samp_ev   = tick && (fcnt[SB-1:0] == SB'(SLOT/2 - 1));
    play_pop  = fetch && play_en && !play_empty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fcnt       <= '0;
      hold       <= '0;
      tx_sr      <= '0;
      rx_sr      <= '0;
      pop_q      <= 1'b0;
      rec_pend   <= 1'b0;
      rec_armed  <= 1'b0;
      underrun_o <= 1'b0;
      rec_push_o <= 1'b0;
      rec_word_o <= '0;
      lrck_o     <= 1'b1;
      bclk_o     <= 1'b0;
    end else begin
      pop_q      <= play_pop;
      underrun_o <= fetch && play_en && play_empty;
      rec_push_o <= frame_end && rec_armed && rec_en;
      if (frame_end) rec_word_o <= rx_sr;

      if (fetch) begin
        hold     <= '0;
        rec_pend <= rec_en;
      end else if (pop_q) begin
        hold <= play_word;
      end

      if (samp_ev) rx_sr <= {rx_sr[W-2:0], sdi_i};

      if (frame_end) begin
        tx_sr     <= hold;
        rec_armed <= rec_pend;
      end else if (shift_ev) begin
        tx_sr <= {tx_sr[W-2:0], 1'b0};
      end

      if (tick) begin
        fcnt   <= fcnt + 1'b1;
        lrck_o <= ((fcnt + 1'b1) < FCW'(FRAME_LEN / 2));
        bclk_o <= (fcnt[SB-1:0] + 1'b1) >= SB'(SLOT / 2);
      end
    end
  end

  assign sdo_o = tx_sr[W-1];

  AST_LRCK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(lrck_o)); // R3

endmodule

// File: rtl/audio_fifo_ctrl.sv
module audio_fifo_ctrl
  import audio_fifo_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int DIV_W     = 5,
  parameter int FRAME_LEN = 256,
  localparam int LW       = $clog2(DEPTH) + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [SAMPLE_W-1:0] bus_wdata,
  output logic [SAMPLE_W-1:0] bus_rdata,
  output logic                play_dreq,
  output logic                rec_dreq,
  output logic                mclk_o,
  output logic                lrck_o,
  output logic                bclk_o,
  output logic                sdo_o,
  input  logic                sdi_i
);

  logic                 play_en, rec_en;
  logic [NUM_FLAGS-1:0] flags, flag_set, flag_clr;
  logic [DIV_W-1:0]     div_q;
  logic                 wr_ctrl, wr_play, rd_rec;
  logic                 play_flush, rec_flush;
  logic                 play_full, play_empty, rec_full, rec_empty;
  logic [LW-1:0]        play_lvl, rec_lvl;
  logic [SAMPLE_W-1:0]  play_dout, rec_dout, rec_word, reg_q;
  logic                 play_pop, underrun, rec_push, tick;
  logic                 rec_sel_q, rec_void_q;

  assign wr_ctrl    = bus_wr && (bus_addr == REG_CTRL);
  assign wr_play    = bus_wr && (bus_addr == REG_PLAY);
  assign rd_rec     = bus_rd && (bus_addr == REG_REC);
  assign play_flush = wr_ctrl && play_en && !bus_wdata[0];
  assign rec_flush  = wr_ctrl && rec_en && !bus_wdata[1];

  always_comb begin
    flag_set = '0;
    flag_set[FLAG_PLAY_OVF] = wr_play && play_full;
    flag_set[FLAG_PLAY_UNF] = underrun;
    flag_set[FLAG_REC_OVF]  = rec_push && rec_full;
    flag_set[FLAG_REC_UNF]  = rd_rec && rec_empty;
    flag_clr = wr_ctrl ? bus_wdata[FLAG_BASE +: NUM_FLAGS] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      play_en   <= 1'b0;
      rec_en    <= 1'b0;
      flags     <= '0;
      div_q     <= '0;
      play_dreq <= 1'b0;
      rec_dreq  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        play_en <= bus_wdata[0];
        rec_en  <= bus_wdata[1];
      end
      if (bus_wr && (bus_addr == REG_MCLKDIV)) div_q <= bus_wdata[DIV_W-1:0];
      // a new event wins over a clear in the same cycle
      flags     <= (flags & ~flag_clr) | flag_set;
      play_dreq <= play_en && (play_lvl <= LW'(DEPTH / 2));
      rec_dreq  <= rec_en && (rec_lvl >= LW'(DEPTH / 2));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q      <= '0;
      rec_sel_q  <= 1'b0;
      rec_void_q <= 1'b0;
    end else begin
      rec_sel_q  <= rd_rec;
      rec_void_q <= rd_rec && rec_empty;
      if (bus_rd) begin
        reg_q <= '0;
        case (bus_addr)
          REG_CTRL:    reg_q[1:0] <= {rec_en, play_en};
          REG_STATUS: begin
            reg_q[0] <= play_en;
            reg_q[1] <= rec_en;
            reg_q[FLAG_BASE +: NUM_FLAGS] <= flags;
            reg_q[PLAY_LVL_LSB +: LW]     <= play_lvl;
            reg_q[REC_LVL_LSB +: LW]      <= rec_lvl;
          end
          REG_MCLKDIV: reg_q[DIV_W-1:0] <= div_q;
          default:     reg_q <= '0;
        endcase
      end
    end
  end

  assign bus_rdata = rec_sel_q ? (rec_void_q ? '0 : rec_dout) : reg_q;

  audio_sync_fifo #(.W(SAMPLE_W), .DEPTH(DEPTH)) u_play_fifo (
    .clk(clk), .rst(rst), .flush(play_flush),
    .push(wr_play), .din(bus_wdata),
    .pop(play_pop), .dout(play_dout),
    .level(play_lvl), .full(play_full), .empty(play_empty)
  );

  audio_sync_fifo #(.W(SAMPLE_W), .DEPTH(DEPTH)) u_rec_fifo (
    .clk(clk), .rst(rst), .flush(rec_flush),
    .push(rec_push), .din(rec_word),
    .pop(rd_rec), .dout(rec_dout),
    .level(rec_lvl), .full(rec_full), .empty(rec_empty)
  );

  audio_mclk_div #(.DIV_W(DIV_W)) u_mclk (
    .clk(clk), .rst(rst), .div(div_q), .mclk_o(mclk_o), .tick_o(tick)
  );

  audio_codec_serdes #(.W(SAMPLE_W), .FRAME_LEN(FRAME_LEN)) u_serdes (
    .clk(clk), .rst(rst), .tick(tick),
    .play_en(play_en), .rec_en(rec_en),
    .play_empty(play_empty), .play_word(play_dout), .play_pop(play_pop),
    .underrun_o(underrun), .rec_push_o(rec_push), .rec_word_o(rec_word),
    .lrck_o(lrck_o), .bclk_o(bclk_o), .sdo_o(sdo_o), .sdi_i(sdi_i)
  );

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    flags[FLAG_PLAY_UNF] && !(wr_ctrl && bus_wdata[FLAG_BASE + FLAG_PLAY_UNF])
      |=> flags[FLAG_PLAY_UNF]); // R8

  AST_PLAY_REQ_OFF: assert property (@(posedge clk) disable iff (rst)
    !play_en |=> !play_dreq); // R10

endmodule

// File: tb/audio_fifo_ctrl_tb.sv
module audio_fifo_ctrl_tb;

  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        play_dreq, rec_dreq, mclk_o, lrck_o, bclk_o, sdo_o;
  logic        sdi_i;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];

  always #5 clk = ~clk;
  assign sdi_i = sdo_o;

  audio_fifo_ctrl #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .play_dreq(play_dreq), .rec_dreq(rec_dreq), .mclk_o(mclk_o),
    .lrck_o(lrck_o), .bclk_o(bclk_o), .sdo_o(sdo_o), .sdi_i(sdi_i)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // driver: push a replay word and remember it for the scoreboard
  task automatic drive_sample(input logic [31:0] d);
    bus_write(3'd3, d);
    exp_q.push_back(d);
  endtask

  task automatic measure_mclk(input int n);
    int hi = 0, lo = 0;
    repeat (80) @(negedge clk);
    while (mclk_o !== 1'b0) @(negedge clk);
    while (mclk_o !== 1'b1) @(negedge clk);
    while (mclk_o === 1'b1) begin hi++; @(negedge clk); end
    while (mclk_o === 1'b0) begin lo++; @(negedge clk); end
    chk("R2 high", hi, (n + 1) / 2);
    chk("R2 low", lo, n / 2);
    chk("R1 period", hi + lo, n);
  endtask

  task automatic wait_lrck_rise();
    @(negedge clk);
    while (lrck_o !== 1'b0) @(negedge clk);
    while (lrck_o !== 1'b1) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int hi, lo, got;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // reset state
    bus_read(3'd1, rd); chk("R11 reset status", rd, 32'h0);
    bus_read(3'd2, rd); chk("R1 reset div", rd, 32'h0);
    chk("R10 reset play_dreq", play_dreq, 1'b0);
    chk("R10 reset rec_dreq", rec_dreq, 1'b0);

    // divider
    bus_write(3'd2, 32'd4);
    bus_read(3'd2, rd); chk("R12 R1 div readback", rd, 32'd4);
    measure_mclk(6);
    bus_write(3'd2, 32'd1);  measure_mclk(3);
    bus_write(3'd2, 32'd31); measure_mclk(33);
    bus_write(3'd2, 32'd0);  measure_mclk(2);

    // frame select timing at divisor 2
    wait_lrck_rise();
    hi = 0; lo = 0;
    while (lrck_o === 1'b1) begin hi++; @(negedge clk); end
    while (lrck_o === 1'b0) begin lo++; @(negedge clk); end
    chk("R3 lrck high", hi, 256);
    chk("R3 lrck low", lo, 256);

    // replay overflow while stopped
    for (int i = 0; i < DEPTH + 1; i++) bus_write(3'd3, 32'h100 + i);
    bus_read(3'd1, rd); chk("R6 full drop", rd, (32'(DEPTH) << 8) | 32'h10);
    repeat (100) @(negedge clk);
    bus_write(3'd0, 32'h0);
    bus_read(3'd1, rd); chk("R8 sticky", rd, (32'(DEPTH) << 8) | 32'h10);
    bus_write(3'd0, 32'h10);
    bus_read(3'd1, rd); chk("R8 clear", rd, 32'(DEPTH) << 8);
    bus_write(3'd0, 32'h1);
    bus_write(3'd0, 32'h0);
    bus_read(3'd1, rd); chk("R9 flush replay", rd, 32'h0);

    // request thresholds
    for (int i = 0; i < 10; i++) bus_write(3'd3, 32'h200 + i);
    bus_write(3'd0, 32'h1);
    repeat (3) @(negedge clk);
    chk("R10 play_dreq above half", play_dreq, 1'b0);
    bus_write(3'd0, 32'h0);
    for (int i = 0; i < DEPTH / 2; i++) bus_write(3'd3, 32'h300 + i);
    bus_write(3'd0, 32'h1);
    repeat (3) @(negedge clk);
    chk("R10 play_dreq at half", play_dreq, 1'b1);
    bus_write(3'd0, 32'h0);
    bus_write(3'd0, 32'hF0);

    // loopback scoreboard
    for (int i = 0; i < 6; i++) drive_sample(32'hA5C3_1234 + 32'h0101_0101 * i);
    wait_lrck_rise();
    bus_write(3'd0, 32'h3);
    wait_lrck_rise();
    repeat (8) @(negedge clk);
    chk("R3 sdo msb first", sdo_o, exp_q[0][31]);
    repeat (16) @(negedge clk);
    chk("R3 sdo second bit", sdo_o, exp_q[0][30]);
    got = 0;
    while (got < 9) begin
      bus_read(3'd1, rd);
      if (rd[20:16] != 0) begin
        bus_read(3'd4, rd);
        if (exp_q.size() > 0) chk("R4 loopback word", rd, exp_q.pop_front());
        else chk("R5 zero after underrun", rd, 32'h0);
        got++;
      end
    end
    bus_read(3'd1, rd); chk("R5 underflow flag", rd[5], 1'b1);
    bus_write(3'd0, 32'hF0);

    // record overflow, unattended capture
    bus_write(3'd0, 32'h2);
    rd = '0;
    while (rd[20:16] < 5'(DEPTH / 2)) bus_read(3'd1, rd);
    repeat (2) @(negedge clk);
    chk("R10 rec_dreq at half", rec_dreq, 1'b1);
    repeat (20 * 512) @(negedge clk);
    bus_read(3'd1, rd); chk("R7 rec overflow", rd, (32'(DEPTH) << 16) | 32'h42);
    bus_write(3'd0, 32'h0);
    repeat (2) @(negedge clk);
    chk("R10 rec_dreq off", rec_dreq, 1'b0);
    bus_read(3'd4, rd); chk("R7 empty read zero", rd, 32'h0);
    bus_read(3'd1, rd); chk("R9 R7 flush and underflow", rd, 32'hC0);
    bus_write(3'd0, 32'hF0);
    bus_read(3'd1, rd); chk("R8 clear all", rd, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule